// File: doc/BRIEF.md
# Keyed Register Write Guard

This block sits in front of a peripheral's configuration register file and decides, write by write, whether a register update may reach it. A guard-mode register holds a single lock bit. The lock bit can only be changed by a write that carries a fixed 24-bit key in its upper bits. While the lock is set, every write aimed at the guarded part of the address space is suppressed. Each suppressed write is recorded as a violation.

A violation log keeps a flag and the byte offset of the first offending write. The log is visible through a status register that clears itself when read. A mode write with a wrong key is also treated as a violation and leaves the lock bit unchanged. The register file being guarded is outside this block: it only sees the `wr_allow` qualifier that goes with each write strobe.

The guarded space is every offset below the guard-mode register (0x1E4). The status register sits at 0x1E8. Offsets above the status register pass without checks.

Top module: `keyed_wprot`

## Requirements
- R1: After a synchronous active-low reset the lock bit is 0, the violation flag and source are 0, `rd_data` is 0 and `wr_allow` is 0.
- R2: A write to offset 0x1E4 whose data bits 31:8 equal 0x444D41 loads data bit 0 into the lock bit. A read of 0x1E4 returns the lock bit in bit 0 and zeros in all other bits.
- R3: A write to 0x1E4 whose bits 31:8 differ from 0x444D41 leaves the lock bit unchanged. It records a violation with source 0x1E4.
- R4: While the lock bit is 0, a write to an offset below 0x1E4 raises `wr_allow` in the same cycle and records no violation.
- R5: While the lock bit is 1, a write to an offset below 0x1E4 keeps `wr_allow` low. It sets the violation flag and records that offset as the source.
- R6: Writes to 0x1E4 and 0x1E8 never raise `wr_allow`. Writes to offsets above 0x1E8 always raise `wr_allow` and never record a violation.
- R7: A read of 0x1E8 returns on `rd_data` one cycle later a word with the violation flag in bit 0, the source in bits 23:8 and zeros elsewhere. The read clears the flag and the source.
- R8: Once a violation is pending, later violations before a status read leave the source at the first offending offset.
- R9: A violation in the same cycle as a status read does not appear in that read. It is held for the next read.
- R10: A write to 0x1E8 changes neither the flag nor the source, and records no violation.
- R11: `wr_allow` is low in every cycle where `wr_en` is low. `rd_data` is 0 in a cycle after no read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_off | input | 9 | Byte offset of the write |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_off | input | 9 | Byte offset of the read |
| wr_allow | output | 1 | Write may reach the register file (combinational) |
| rd_data | output | 32 | Read data, registered, valid the cycle after `rd_en` |

## Verification
A lock bit stuck at the wrong value shows at the ports at once: the next write to a guarded offset has the wrong `wr_allow` level in that same cycle. The error also shows one cycle after any mode read. A corrupted violation log shows on the first status read that follows, either as a wrong source field or as a flag that survives the clearing read. The bench therefore follows each kind of violation with two status reads. It also reads the status register in the same cycle as a fresh violation, to expose mistakes in how the clear and the capture are ordered.

// File: rtl/wp_pkg.sv
// Shared constants and types of the keyed write guard.
// Assumes a 32-bit data path with the key in bits 31:8.
package wp_pkg;
    localparam int          KEY_W  = 24;
    localparam logic [23:0] WP_KEY = 24'h444D41;

    // Address region of an offset, as seen by the guard
    typedef enum logic [1:0] {
        RG_GUARDED = 2'd0,
        RG_MODE    = 2'd1,
        RG_STATUS  = 2'd2,
        RG_OPEN    = 2'd3
    } region_e;
endpackage

// File: rtl/wp_decode.sv
// Classifies a byte offset into guarded, mode, status or open space.
// Assumes MODE_OFF < STAT_OFF and both fit in ADDR_W bits.
module wp_decode
    import wp_pkg::*;
#(
    parameter int ADDR_W   = 9,
    parameter int MODE_OFF = 'h1E4,
    parameter int STAT_OFF = 'h1E8
) (
    input  logic [ADDR_W-1:0] off,
    output region_e           region
);
    localparam logic [ADDR_W-1:0] MODE_A = ADDR_W'(MODE_OFF);
    localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_OFF);

    // Compare the offset against the two guard registers
    always_comb begin
        if (off < MODE_A)       region = RG_GUARDED;
        else if (off == MODE_A) region = RG_MODE;
        else if (off == STAT_A) region = RG_STATUS;
        else                    region = RG_OPEN;
    end
endmodule

// File: rtl/wp_mode_reg.sv
// Holds the lock bit; only a correctly keyed mode write can change it.
// Assumes mode_wr is a single-cycle qualified write strobe.
module wp_mode_reg
    import wp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_wr,
    input  logic [KEY_W-1:0] key_in,
    input  logic             lock_in,
    output logic             lock,
    output logic             key_bad
);
    logic key_ok;

    // Key comparison for the current mode write
    always_comb begin
        key_ok  = (key_in == WP_KEY);
        key_bad = mode_wr && !key_ok;
    end

    // Lock bit update on a keyed write
    always_ff @(posedge clk) begin
        if (!rst_n)                lock <= 1'b0;
        else if (mode_wr && key_ok) lock <= lock_in;
    end
endmodule

// File: rtl/wp_viol_log.sv
// Violation flag plus first-offender source, cleared by a status read.
// Assumes clr marks a status read whose result was sampled this cycle.
module wp_viol_log #(
    parameter int ADDR_W = 9,
    parameter int SRC_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              viol_now,
    input  logic [ADDR_W-1:0] viol_off,
    input  logic              clr,
    output logic              flag,
    output logic [SRC_W-1:0]  src
);
    // Capture first violation, clear on read, re-arm with a same-cycle hit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
            src  <= '0;
        end else if (viol_now && (!flag || clr)) begin
            flag <= 1'b1;
            src  <= SRC_W'(viol_off);
        end else if (clr) begin
            flag <= 1'b0;
            src  <= '0;
        end
    end
endmodule

// File: rtl/keyed_wprot.sv
// Keyed write guard: gates writes into a configuration register file,
// logs blocked writes and exposes lock and log through two registers.
// Assumes one write and one read port, each at most one access per cycle.
module keyed_wprot
    import wp_pkg::*;
#(
    parameter int ADDR_W   = 9,
    parameter int DATA_W   = 32,
    parameter int SRC_W    = 16,
    parameter int SRC_LSB  = 8,
    parameter int MODE_OFF = 'h1E4,
    parameter int STAT_OFF = 'h1E8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_off,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_off,
    output logic              wr_allow,
    output logic [DATA_W-1:0] rd_data
);
    localparam int KEY_LSB = DATA_W - KEY_W;

    region_e           wr_region;
    region_e           rd_region;
    logic              lock;
    logic              key_bad;
    logic              viol_now;
    logic              stat_rd;
    logic              viol_flag;
    logic [SRC_W-1:0]  viol_src;
    logic [DATA_W-1:0] stat_word;
    logic              unused_bits;

    assign unused_bits = ^wr_data[KEY_LSB-1:1];

    // One decoder per access port
    for (genvar p = 0; p < 2; p++) begin : g_dec
        if (p == 0) begin : g_wr
            wp_decode #(.ADDR_W(ADDR_W), .MODE_OFF(MODE_OFF), .STAT_OFF(STAT_OFF))
                u_dec (.off(wr_off), .region(wr_region));
        end else begin : g_rd
            wp_decode #(.ADDR_W(ADDR_W), .MODE_OFF(MODE_OFF), .STAT_OFF(STAT_OFF))
                u_dec (.off(rd_off), .region(rd_region));
        end
    end

    wp_mode_reg u_mode (
        .clk    (clk),
        .rst_n  (rst_n),
        .mode_wr(wr_en && (wr_region == RG_MODE)),
        .key_in (wr_data[DATA_W-1:KEY_LSB]),
        .lock_in(wr_data[0]),
        .lock   (lock),
        .key_bad(key_bad)
    );

    // Write qualification and violation detection
    always_comb begin
        wr_allow = wr_en && ((wr_region == RG_OPEN) ||
                             (wr_region == RG_GUARDED && !lock));
        viol_now = key_bad || (wr_en && lock && (wr_region == RG_GUARDED));
        stat_rd  = rd_en && (rd_region == RG_STATUS);
    end

    wp_viol_log #(.ADDR_W(ADDR_W), .SRC_W(SRC_W)) u_log (
        .clk     (clk),
        .rst_n   (rst_n),
        .viol_now(viol_now),
        .viol_off(wr_off),
        .clr     (stat_rd),
        .flag    (viol_flag),
        .src     (viol_src)
    );

    // Status word layout: flag at bit 0, source above SRC_LSB
    always_comb begin
        stat_word                   = '0;
        stat_word[0]                = viol_flag;
        stat_word[SRC_LSB +: SRC_W] = viol_src;
    end

    // Registered read mux; idle cycles return zero
    always_ff @(posedge clk) begin
        if (!rst_n)            rd_data <= '0;
        else if (!rd_en)       rd_data <= '0;
        else if (rd_region == RG_MODE)
                               rd_data <= DATA_W'(lock);
        else if (stat_rd)      rd_data <= stat_word;
        else                   rd_data <= '0;
    end
endmodule

// File: rtl/keyed_wprot_chk.sv
// Property checker for keyed_wprot, bound to every instance.
// Assumes the default 32-bit data layout with the key in bits 31:8.
module keyed_wprot_chk
    import wp_pkg::*;
#(
    parameter int ADDR_W   = 9,
    parameter int SRC_W    = 16,
    parameter int MODE_OFF = 'h1E4,
    parameter int STAT_OFF = 'h1E8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_off,
    input logic [31:0]       wr_data,
    input logic              rd_en,
    input logic [ADDR_W-1:0] rd_off,
    input logic              wr_allow,
    input logic              lock,
    input logic              viol_now,
    input logic              viol_flag,
    input logic [SRC_W-1:0]  viol_src
);
    localparam logic [ADDR_W-1:0] MODE_A = ADDR_W'(MODE_OFF);
    localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_OFF);

    // R11
    idle_no_allow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |-> !wr_allow);

    // R5
    locked_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && lock && wr_off < MODE_A) |-> !wr_allow);

    // R5
    locked_logs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && lock && wr_off < MODE_A) |=> viol_flag);

    // R2
    good_key_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_off == MODE_A && wr_data[31:8] == WP_KEY)
        |=> (lock == $past(wr_data[0])));

    // R3
    bad_key_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_off == MODE_A && wr_data[31:8] != WP_KEY) |=> $stable(lock));

    // R8
    first_src_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (viol_flag && !(rd_en && rd_off == STAT_A)) |=> $stable(viol_src) && viol_flag);

    // R7
    read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_off == STAT_A && !viol_now) |=> !viol_flag && viol_src == '0);

    // R6
    guard_regs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_off == MODE_A || wr_off == STAT_A)) |-> !wr_allow);
endmodule

bind keyed_wprot keyed_wprot_chk #(
    .ADDR_W(ADDR_W), .SRC_W(SRC_W), .MODE_OFF(MODE_OFF), .STAT_OFF(STAT_OFF)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_off   (wr_off),
    .wr_data  (wr_data),
    .rd_en    (rd_en),
    .rd_off   (rd_off),
    .wr_allow (wr_allow),
    .lock     (lock),
    .viol_now (viol_now),
    .viol_flag(viol_flag),
    .viol_src (viol_src)
);

// File: tb/test_keyed_wprot.sv
// Self-checking bench: vector table walk, then reset and corner cases.
module test_keyed_wprot;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [8:0]  wr_off = '0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [8:0]  rd_off = '0;
    logic        wr_allow;
    logic [31:0] rd_data;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    keyed_wprot i_keyed_wprot (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_off(wr_off),
        .wr_data(wr_data), .rd_en(rd_en), .rd_off(rd_off),
        .wr_allow(wr_allow), .rd_data(rd_data)
    );

    typedef struct packed {
        logic        is_rd;
        logic [8:0]  off;
        logic [31:0] data;
        logic [31:0] exp;
        logic [7:0]  req;
    } vec_t;

    // exp = wr_allow for writes, rd_data for reads
    localparam int NV = 18;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 9'h010, 32'hA5A5_0001, 32'd1,          8'd4},  // R4 open write
        '{1'b1, 9'h1E8, 32'h0,         32'h0,          8'd7},  // R7 clean status
        '{1'b0, 9'h1E4, 32'h444D_4101, 32'd0,          8'd6},  // R6/R2 lock
        '{1'b1, 9'h1E4, 32'h0,         32'd1,          8'd2},  // R2 lock reads 1
        '{1'b0, 9'h03C, 32'h1234_5678, 32'd0,          8'd5},  // R5 blocked
        '{1'b0, 9'h064, 32'h0000_0000, 32'd0,          8'd8},  // R8 second hit
        '{1'b0, 9'h1F0, 32'hFFFF_FFFF, 32'd1,          8'd6},  // R6 open space
        '{1'b1, 9'h1E8, 32'h0,         32'h0000_3C01,  8'd8},  // R8 first source
        '{1'b1, 9'h1E8, 32'h0,         32'h0,          8'd7},  // R7 cleared
        '{1'b0, 9'h1E4, 32'h1234_5600, 32'd0,          8'd3},  // R3 wrong key
        '{1'b1, 9'h1E4, 32'h0,         32'd1,          8'd3},  // R3 lock kept
        '{1'b1, 9'h1E8, 32'h0,         32'h0001_E401,  8'd3},  // R3 source
        '{1'b0, 9'h1E8, 32'hFFFF_FFFF, 32'd0,          8'd10}, // R10 status wr
        '{1'b1, 9'h1E8, 32'h0,         32'h0,          8'd10}, // R10 no effect
        '{1'b0, 9'h1E4, 32'h444D_4100, 32'd0,          8'd2},  // R2 unlock
        '{1'b1, 9'h1E4, 32'h0,         32'h0,          8'd2},  // R2 reads 0
        '{1'b0, 9'h0FC, 32'h0000_0042, 32'd1,          8'd4},  // R4 open again
        '{1'b1, 9'h1E8, 32'h0,         32'h0,          8'd4}   // R4 no violation
    };

    task automatic check(input logic ok, input int req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL R%0d: actual %h expected %h", req, act, exp);
        end
    endtask

    // Write at a falling edge; wr_allow is checked before the rising edge
    task automatic do_write(input logic [8:0] off, input logic [31:0] d,
                            input logic exp, input int req);
        wr_en = 1'b1; wr_off = off; wr_data = d;
        #1 check(wr_allow == exp, req, 32'(wr_allow), 32'(exp));
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Read at a falling edge; rd_data is checked one edge later
    task automatic do_read(input logic [8:0] off, input logic [31:0] exp,
                           input int req);
        rd_en = 1'b1; rd_off = off;
        #1 check(wr_allow == 1'b0, 11, 32'(wr_allow), 32'd0); // R11
        @(negedge clk);
        rd_en = 1'b0;
        check(rd_data == exp, req, rd_data, exp);
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check(rd_data == 32'h0, 1, rd_data, 32'h0);
        check(wr_allow == 1'b0, 1, 32'(wr_allow), 32'h0);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i].is_rd) do_read(VEC[i].off, VEC[i].exp, int'(VEC[i].req));
            else do_write(VEC[i].off, VEC[i].data, VEC[i].exp[0], int'(VEC[i].req));
        end

        // R11 idle cycle after a read returns zero
        @(negedge clk);
        check(rd_data == 32'h0, 11, rd_data, 32'h0);

        // R9 violation in the same cycle as a status read
        do_write(9'h1E4, 32'h444D_4101, 1'b0, 2);
        do_write(9'h020, 32'h0, 1'b0, 5);
        wr_en = 1'b1; wr_off = 9'h040; wr_data = 32'h0;
        rd_en = 1'b1; rd_off = 9'h1E8;
        #1 check(wr_allow == 1'b0, 9, 32'(wr_allow), 32'h0);
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        check(rd_data == 32'h0000_2001, 9, rd_data, 32'h0000_2001);
        do_read(9'h1E8, 32'h0000_4001, 9);
        do_read(9'h1E8, 32'h0, 9);

        // R1 reset with lock and a pending violation
        do_write(9'h000, 32'h0, 1'b0, 5);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        do_read(9'h1E4, 32'h0, 1);
        do_read(9'h1E8, 32'h0, 1);
        do_write(9'h000, 32'h0, 1'b1, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule